// File: doc/BRIEF.md
# Synchronous serial frame receiver

This block takes frames off a single data line that is sampled on the rising edge of a serial clock. While receive mode is selected it watches for a low start bit. It then collects eight data bits (least significant first), one even-parity bit and two high stop bits. When the second stop bit is captured it either hands the byte to the access layer with a one-cycle strobe or reports exactly one class of exception: a stop-bit fault, a parity mismatch, or a break, where the whole frame is zero.

A stop-bit fault or a parity mismatch puts the receiver into a locked condition. It keeps framing the line, but no frame yields a byte or a flag until a break character arrives. The break is reported and releases the lock. When the mode-select input is low (the line is being driven by the transmit side), any partial frame is dropped and nothing is reported, but the lock is kept.

Top module: `rxf_receiver`

## Requirements
- R1: After reset the receiver is unlocked and hunting for a start bit, all strobes and flags are low, and `rx_data` is zero.
- R2: A frame is a 0 start bit, 8 data bits LSB first, a parity bit that makes the number of ones among data and parity even, and two stop bits of 1. Every bit is sampled on the rising clock edge. Reception begins on the first edge at which the line is sampled low while hunting.
- R3: For a frame with no exception, `rx_valid` is high for exactly one cycle following the edge that samples the second stop bit, and `rx_data` takes the byte at that same edge. `rx_data` changes at no other time.
- R4: `err_frame` pulses at the frame-end point when either stop bit is sampled as 0 and the frame is not a break.
- R5: `err_parity` pulses at the frame-end point when the parity bit does not give even parity over data and parity, and the frame is not a break. It may pulse together with `err_frame`.
- R6: A frame whose 12 bits are all 0 raises only `err_break`, never `err_frame` or `err_parity`.
- R7: After `err_frame` or `err_parity`, every following frame that is not a break produces no strobe and no flag, and `rx_data` is left unchanged.
- R8: A break is reported whether the receiver is locked or not, and it leaves the receiver unlocked, so the next good frame is delivered.
- R9: While `rx_en` is low, no strobe or flag is raised and any partial frame is discarded. The locked condition survives a period with `rx_en` low.
- R10: A new start bit may be sampled on the edge directly after the second stop bit, and back-to-back frames are each received.
- R11: At most one of the three outcome classes (valid, frame/parity error, break) is signalled per frame, and every strobe and flag lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | High selects receive mode |
| din | input | 1 | Sampled level of the data line |
| rx_data | output | 8 | Last byte delivered without exception |
| rx_valid | output | 1 | One-cycle strobe for a delivered byte |
| err_frame | output | 1 | One-cycle flag: a stop bit was low |
| err_parity | output | 1 | One-cycle flag: parity mismatch |
| err_break | output | 1 | One-cycle flag: an all-zero frame was received |

## Verification
A bit counter that slips by one moves every byte one position and shifts the parity and stop slots. The first frame after the slip then shows a wrong `rx_data` or a spurious `err_frame`, exactly one edge after the expected second stop bit. A stale lock bit shows up on the next good frame as a missing `rx_valid`. A lock that clears too early shows up as a delivered byte where none is due. The outputs are compared on every frame of an exhaustive byte sweep, and each byte is followed by an error frame, a frame that must be ignored and an unlocking break, so any of these faults shows within one frame of the state going wrong.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic frame_err;
        logic parity_err;
        logic brk;
    } rx_event_t;

endpackage

// File: rtl/rxf_bit_counter.sv
`timescale 1ns/1ps
module rxf_bit_counter #(
    parameter int unsigned SLOTS = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           adv_i,
    output logic [$clog2(SLOTS+1)-1:0]     idx_o,
    output logic                           last_o
);
    localparam int unsigned CW = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] LASTV = CW'(SLOTS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
        end else if (adv_i) begin
            if (q.cnt == LASTV) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign idx_o  = q.cnt;
    assign last_o = adv_i && (q.cnt == LASTV);

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LASTV);                                            // R2
    AST_RESTART_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (q.cnt == '0));                                  // R10

endmodule

// File: rtl/rxf_shifter.sv
`timescale 1ns/1ps
module rxf_shifter #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_W = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      clr_i,
    input  logic                                      shift_en_i,
    input  logic                                      bit_i,
    input  logic [$clog2(DATA_W+1+STOP_W+1)-1:0]      idx_i,
    output logic [DATA_W+STOP_W:0]                    frame_nx_o,
    output logic                                      par_nx_o,
    output logic                                      seen_one_nx_o
);
    localparam int unsigned SLOTS = DATA_W + 1 + STOP_W;
    localparam int unsigned IW    = $clog2(SLOTS + 1);
    localparam logic [IW-1:0] PAR_SLOT = IW'(DATA_W);

    typedef struct packed {
        logic [SLOTS-1:0] frame;
        logic             par;
        logic             seen;
    } sh_st_t;

    sh_st_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else if (shift_en_i) begin
            d.frame = {bit_i, q.frame[SLOTS-1:1]};
            d.seen  = q.seen | bit_i;
            if (idx_i < PAR_SLOT) begin
                d.par = q.par ^ bit_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign frame_nx_o    = d.frame;
    assign par_nx_o      = d.par;
    assign seen_one_nx_o = d.seen;

    AST_PARITY_TRACKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en_i && idx_i == PAR_SLOT) |-> (q.par == ^q.frame[SLOTS-1 -: DATA_W])); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.seen == 1'b0 && q.par == 1'b0));              // R2

endmodule

// File: rtl/rxf_frame_ctrl.sv
`timescale 1ns/1ps
module rxf_frame_ctrl
    import rxf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_en_i,
    input  logic                         din_i,
    input  logic                         last_i,
    input  logic [DATA_W+STOP_W:0]       frame_nx_i,
    input  logic                         par_nx_i,
    input  logic                         seen_one_nx_i,
    output logic                         shifting_o,
    output logic [DATA_W-1:0]            data_o,
    output rx_event_t                    evt_o
);
    localparam int unsigned SLOTS = DATA_W + 1 + STOP_W;

    typedef struct packed {
        rx_state_e         state;
        logic              locked;
        logic [DATA_W-1:0] data;
        rx_event_t         evt;
    } ctrl_st_t;

    ctrl_st_t q, d;
    logic stop_bad;
    logic par_bad;
    logic is_break;

    always_comb begin
        stop_bad = ~&frame_nx_i[SLOTS-1 -: STOP_W];
        par_bad  = par_nx_i ^ frame_nx_i[DATA_W];
        is_break = ~seen_one_nx_i;

        d     = q;
        d.evt = '0;
        if (!rx_en_i) begin
            d.state = RX_HUNT;
        end else begin
            case (q.state)
                RX_HUNT: begin
                    if (!din_i) begin
                        d.state = RX_SHIFT;
                    end
                end
                RX_SHIFT: begin
                    if (last_i) begin
                        d.state = RX_HUNT;
                        if (is_break) begin
                            d.evt.brk = 1'b1;
                            d.locked  = 1'b0;
                        end else if (!q.locked) begin
                            if (stop_bad || par_bad) begin
                                d.evt.frame_err  = stop_bad;
                                d.evt.parity_err = par_bad;
                                d.locked         = 1'b1;
                            end else begin
                                d.evt.valid = 1'b1;
                                d.data      = frame_nx_i[DATA_W-1:0];
                            end
                        end
                    end
                end
                default: d.state = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign shifting_o = rx_en_i && (q.state == RX_SHIFT);
    assign data_o     = q.data;
    assign evt_o      = q.evt;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.evt.valid, q.evt.frame_err | q.evt.parity_err, q.evt.brk})); // R11
    AST_EVENT_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.evt != '0) |=> (q.evt == '0));                            // R11
    AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.data) |-> q.evt.valid);                          // R3
    AST_ERROR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.evt.frame_err || q.evt.parity_err) |-> q.locked);        // R7
    AST_LOCKED_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |=> !q.evt.valid);                                 // R7
    AST_BREAK_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        q.evt.brk |-> !q.locked);                                   // R8

endmodule

// File: rtl/rxf_receiver.sv
`timescale 1ns/1ps
module rxf_receiver
    import rxf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              din,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_break
);
    localparam int unsigned SLOTS = DATA_W + 1 + STOP_W;
    localparam int unsigned IW    = $clog2(SLOTS + 1);

    logic             shifting;
    logic [IW-1:0]    slot_idx;
    logic             slot_last;
    logic [SLOTS-1:0] frame_nx;
    logic             par_nx;
    logic             seen_one_nx;
    rx_event_t        evt;

    rxf_bit_counter #(
        .SLOTS (SLOTS)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!shifting),
        .adv_i  (shifting),
        .idx_o  (slot_idx),
        .last_o (slot_last)
    );

    rxf_shifter #(
        .DATA_W (DATA_W),
        .STOP_W (STOP_W)
    ) u_shf (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (!shifting),
        .shift_en_i    (shifting),
        .bit_i         (din),
        .idx_i         (slot_idx),
        .frame_nx_o    (frame_nx),
        .par_nx_o      (par_nx),
        .seen_one_nx_o (seen_one_nx)
    );

    rxf_frame_ctrl #(
        .DATA_W (DATA_W),
        .STOP_W (STOP_W)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en_i       (rx_en),
        .din_i         (din),
        .last_i        (slot_last),
        .frame_nx_i    (frame_nx),
        .par_nx_i      (par_nx),
        .seen_one_nx_i (seen_one_nx),
        .shifting_o    (shifting),
        .data_o        (rx_data),
        .evt_o         (evt)
    );

    assign rx_valid   = evt.valid;
    assign err_frame  = evt.frame_err;
    assign err_parity = evt.parity_err;
    assign err_break  = evt.brk;

    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !(rx_valid || err_frame || err_parity || err_break)); // R9

endmodule

// File: tb/sim_rxf_receiver.sv
`timescale 1ns/1ps
module sim_rxf_receiver;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       din = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, err_frame, err_parity, err_break;

    int unsigned vec  = 0;
    int unsigned miss = 0;
    logic        model_locked = 1'b0;
    logic [7:0]  exp_data = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    rxf_receiver u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .din        (din),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_frame  (err_frame),
        .err_parity (err_parity),
        .err_break  (err_break)
    );

    function automatic logic [11:0] mk(input logic [7:0] d, input bit flip, input logic [1:0] st);
        return {st, (^d) ^ flip, d, 1'b0};
    endfunction

    task automatic cmp(input string tag, input logic [11:0] exp);
        logic [11:0] got;
        got = {rx_valid, err_frame, err_parity, err_break, rx_data};
        vec++;
        if (got !== exp) begin
            miss++;
            $display("FAIL %s: got v/f/p/b=%b data=%h expected v/f/p/b=%b data=%h",
                     tag, got[11:8], got[7:0], exp[11:8], exp[7:0]);
        end
    endtask

    task automatic xfer(input logic [11:0] fr, input bit started, input bit chain, input string tag);
        logic e_v, e_f, e_p, e_b, sb, pb;
        for (int i = (started ? 1 : 0); i < 12; i++) begin
            @(negedge clk);
            din = fr[i];
        end
        @(negedge clk);
        e_v = 1'b0; e_f = 1'b0; e_p = 1'b0; e_b = 1'b0;
        sb = !(fr[10] && fr[11]);
        pb = ^fr[9:1];
        if (fr == 12'h000) begin
            e_b = 1'b1;
            model_locked = 1'b0;
        end else if (!model_locked) begin
            if (sb || pb) begin
                e_f = sb;
                e_p = pb;
                model_locked = 1'b1;
            end else begin
                e_v = 1'b1;
                exp_data = fr[8:1];
            end
        end
        cmp(tag, {e_v, e_f, e_p, e_b, exp_data});
        din = chain ? 1'b0 : 1'b1;
    endtask

    task automatic quiet(input string tag);
        @(negedge clk);
        cmp(tag, {4'b0000, exp_data});
    endtask

    task automatic drive_off(input logic [11:0] fr, input string tag);
        @(negedge clk);
        rx_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            din = fr[i];
            cmp(tag, {4'b0000, exp_data});
        end
        @(negedge clk);
        din = 1'b1;
        cmp(tag, {4'b0000, exp_data});
        rx_en = 1'b1;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        miss++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [11:0] bad;
        logic [7:0]  v;
        string       btag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 reset state", 12'h000);

        xfer(mk(8'hA5, 1'b0, 2'b11), 1'b0, 1'b0, "R2 R3 good A5");
        quiet("R11 strobe lasts one cycle");
        xfer(mk(8'h01, 1'b0, 2'b11), 1'b0, 1'b0, "R2 LSB first 01");
        xfer(mk(8'h80, 1'b0, 2'b11), 1'b0, 1'b0, "R2 LSB first 80");

        for (int d = 0; d < 256; d++) begin
            v = 8'(d);
            xfer(mk(v, 1'b0, 2'b11), 1'b0, 1'b0, "R3 sweep good byte");
            if (d % 64 == 0) begin
                bad = mk(v, 1'b0, 2'b00);
                btag = "R4 R6 both stops low";
            end else begin
                case (d % 4)
                    0: begin bad = mk(v, 1'b1, 2'b11); btag = "R5 parity flip"; end
                    1: begin bad = mk(v, 1'b0, 2'b10); btag = "R4 first stop low"; end
                    2: begin bad = mk(v, 1'b0, 2'b01); btag = "R4 second stop low"; end
                    default: begin bad = mk(v, 1'b1, 2'b00); btag = "R4 R5 both faults"; end
                endcase
            end
            xfer(bad, 1'b0, 1'b0, btag);
            quiet("R11 flag lasts one cycle");
            xfer(mk(~v, 1'b0, 2'b11), 1'b0, 1'b0, "R7 locked ignores good");
            xfer(12'h000, 1'b0, 1'b0, "R8 break unlocks");
        end

        xfer(mk(8'h3C, 1'b0, 2'b11), 1'b0, 1'b1, "R10 chain first");
        xfer(mk(8'hC3, 1'b0, 2'b11), 1'b1, 1'b1, "R10 chain second");
        xfer(mk(8'h5A, 1'b1, 2'b11), 1'b1, 1'b1, "R10 chain parity fault");
        xfer(mk(8'h99, 1'b0, 2'b01), 1'b1, 1'b0, "R7 locked ignores bad");
        xfer(12'h000, 1'b0, 1'b0, "R6 R8 break while locked");
        xfer(12'h000, 1'b0, 1'b0, "R6 break while unlocked");
        xfer(mk(8'h42, 1'b0, 2'b11), 1'b0, 1'b0, "R8 delivery after break");

        @(negedge clk);
        din = 1'b0;
        repeat (5) begin
            @(negedge clk);
            din = ~din;
        end
        rx_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            cmp("R9 partial frame dropped", {4'b0000, exp_data});
        end
        din = 1'b1;
        rx_en = 1'b1;
        xfer(mk(8'hE7, 1'b0, 2'b11), 1'b0, 1'b0, "R9 good after abort");
        drive_off(mk(8'h18, 1'b0, 2'b11), "R9 off frame ignored");
        xfer(mk(8'h6D, 1'b0, 2'b10), 1'b0, 1'b0, "R4 lock before off");
        drive_off(12'h000, "R9 off break ignored");
        xfer(mk(8'h77, 1'b0, 2'b11), 1'b0, 1'b0, "R9 lock kept across off");
        xfer(12'h000, 1'b0, 1'b0, "R8 break after off");
        xfer(mk(8'hFF, 1'b0, 2'b11), 1'b0, 1'b0, "R3 good FF");
        report();
    end

endmodule